// File: doc/BRIEF.md
# Sticky Fuse-Word Lock Register Bank

This block holds the set-only lock state that guards a bank of fuse words and the shadow copies of those words. Every fuse word has three lock bits. The first blocks refreshing the word's shadow from the fuse array. The second blocks bus writes to the shadow. The third blocks programming the fuse word. Software sets a bit by writing a one to it. A bit stays set until the next reset. Writing zeros to a register never clears anything, so software can set one word's lock without first reading the rest of the register.

The block also has three further registers:
- a global lock register, which can lock the upper region, lock the debug-enable register or block all programming;
- an 11-bit debug-enable register;
- a read-only view of the permanent-lock status that the fuse array reports.

The command sequencer and the shadow array read the per-word inhibit outputs directly. Access is through a plain write strobe and a plain read strobe. Read data comes from a register and appears one cycle after the read strobe.

Top module: `fuse_lock_bank`

## Requirements
- R1: After reset, all lock bits, the global lock bits and the debug-enable register are zero, and so are rdData and every inhibit output.
- R2: There are three lock banks: program lock at byte offset 0x064, shadow-write lock at 0x07C and shadow-refresh lock at 0x094. Each bank has three 32-bit registers 4 bytes apart. Bit b of register k in a bank covers word 32*k+b. A write sets every bit written as 1 and leaves bits written as 0 unchanged. A read returns the bank's current lock bits.
- R3: A lock bit that is set, in any bank or in the global lock register, stays set until reset.
- R4: refreshInhibit[w] equals the shadow-refresh lock of word w, and shadowWrInhibit[w] equals the shadow-write lock of word w.
- R5: progInhibit[w] is 1 when the program lock of word w is set or when global lock bit 3 is set.
- R6: The global lock register sits at offset 0x010. Bits 0, 2 and 3 are write-one-to-set. All other bits read 0. upperLock follows bit 0.
- R7: The debug-enable register sits at offset 0x014. It keeps bits 10:0 of the written data, a read returns that masked value with the upper bits zero, and dbgEnable follows it.
- R8: While global lock bit 2 is set, writes to offset 0x014 are ignored.
- R9: Offsets 0x04C, 0x050 and 0x054 are read-only. Each returns 32 bits of permLockIn, in the same word mapping as R2. Writes to them have no effect.
- R10: A read of any other offset, including an offset that is not a multiple of 4, returns zero, and a write to such an offset changes nothing. rdData updates on the clock edge that samples rdEn, and keeps its value while rdEn is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| addr | input | 12 | Byte offset |
| wrData | input | 32 | Write data |
| permLockIn | input | 96 | Permanent-lock status from the fuse array, one bit per word |
| rdData | output | 32 | Registered read data |
| refreshInhibit | output | 96 | Per-word block on shadow refresh |
| shadowWrInhibit | output | 96 | Per-word block on shadow writes |
| progInhibit | output | 96 | Per-word block on programming |
| upperLock | output | 1 | Upper-region lock |
| dbgEnable | output | 11 | Debug-enable bits |

## Verification
A wrong lock bit shows up right away on the inhibit outputs, on the edge that follows the write. It is therefore compared after every write, not only when a register is read back. A bit that clears, or that sets in the wrong register or word, also shows in the read data one cycle after the read strobe. An address decoded into the wrong bank shows either as a non-zero read from an undefined offset or as a change in the wrong bank's inhibit vector. A debug-enable register that leaks through its lock shows on dbgEnable in the cycle after the write.

// File: rtl/fuse_lock_pkg.sv
package fuse_lock_pkg;

  localparam int unsigned OFF_GLOB = 32'h010;
  localparam int unsigned OFF_DBG  = 32'h014;
  localparam int unsigned OFF_PERM = 32'h04C;
  localparam int unsigned OFF_PROG = 32'h064;
  localparam int unsigned OFF_SWR  = 32'h07C;
  localparam int unsigned OFF_REF  = 32'h094;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_GLOB,
    RD_DBG,
    RD_PERM,
    RD_PROG,
    RD_SWR,
    RD_REF
  } rdSel_e;

  // Strobes from the decoder to the register datapath
  typedef struct packed {
    logic   wrProg;
    logic   wrSwr;
    logic   wrRef;
    logic   wrGlob;
    logic   wrDbg;
    logic   rdStb;
    rdSel_e rdSel;
    logic [7:0] regIdx;
  } lockCmd_t;

endpackage

// File: rtl/fuse_lock_ctrl.sv
module fuse_lock_ctrl
  import fuse_lock_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int REGS   = 3
) (
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  output lockCmd_t          cmd
);

  localparam int unsigned SPAN = 4 * REGS;

  function automatic logic inBank(input logic [ADDR_W-1:0] a, input int unsigned base);
    int unsigned av;
    av = int'(a);
    return (av >= base) && (av < base + SPAN) && (a[1:0] == 2'b00);
  endfunction

  function automatic logic [7:0] bankIdx(input logic [ADDR_W-1:0] a, input int unsigned base);
    int unsigned off;
    off = int'(a) - base;
    return 8'(off >> 2);
  endfunction

  rdSel_e     sel;
  logic [7:0] idx;

  always_comb begin
    sel = RD_NONE;
    idx = '0;
    if (int'(addr) == OFF_GLOB) begin
      sel = RD_GLOB;
    end else if (int'(addr) == OFF_DBG) begin
      sel = RD_DBG;
    end else if (inBank(addr, OFF_PERM)) begin
      sel = RD_PERM;
      idx = bankIdx(addr, OFF_PERM);
    end else if (inBank(addr, OFF_PROG)) begin
      sel = RD_PROG;
      idx = bankIdx(addr, OFF_PROG);
    end else if (inBank(addr, OFF_SWR)) begin
      sel = RD_SWR;
      idx = bankIdx(addr, OFF_SWR);
    end else if (inBank(addr, OFF_REF)) begin
      sel = RD_REF;
      idx = bankIdx(addr, OFF_REF);
    end
  end

  always_comb begin
    cmd        = '0;
    cmd.rdSel  = sel;
    cmd.regIdx = idx;
    cmd.rdStb  = rdEn;
    cmd.wrGlob = wrEn && (sel == RD_GLOB);
    cmd.wrDbg  = wrEn && (sel == RD_DBG);
    cmd.wrProg = wrEn && (sel == RD_PROG);
    cmd.wrSwr  = wrEn && (sel == RD_SWR);
    cmd.wrRef  = wrEn && (sel == RD_REF);
  end

endmodule

// File: rtl/fuse_lock_dp.sv
module fuse_lock_dp
  import fuse_lock_pkg::*;
#(
  parameter int NUM_WORDS = 96,
  parameter int DBG_BITS  = 11
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  lockCmd_t             cmd,
  input  logic [31:0]          wrData,
  input  logic [NUM_WORDS-1:0] permLockIn,
  output logic [31:0]          rdData,
  output logic [NUM_WORDS-1:0] refreshInhibit,
  output logic [NUM_WORDS-1:0] shadowWrInhibit,
  output logic [NUM_WORDS-1:0] progInhibit,
  output logic                 upperLock,
  output logic [DBG_BITS-1:0]  dbgEnable
);

  localparam int WORD_BITS = 32;
  localparam int REGS      = NUM_WORDS / WORD_BITS;
  localparam int KINDS     = 3;   // 0 program, 1 shadow-write, 2 shadow-refresh
  localparam logic [3:0] GLOB_MASK = 4'b1101;

  logic [KINDS-1:0][NUM_WORDS-1:0] lockVec, lockNext;
  logic [3:0]                      globLock;
  logic [DBG_BITS-1:0]             dbgReg;
  logic [KINDS-1:0]                wrKind;
  logic [31:0]                     rdNext;

  logic [REGS-1:0][WORD_BITS-1:0] permWords, progWords, swrWords, refWords;

  assign wrKind = {cmd.wrRef, cmd.wrSwr, cmd.wrProg};

  genvar gr;
  generate
    for (gr = 0; gr < REGS; gr++) begin : g_view
      assign permWords[gr] = permLockIn[gr*WORD_BITS +: WORD_BITS];
      assign progWords[gr] = lockVec[0][gr*WORD_BITS +: WORD_BITS];
      assign swrWords[gr]  = lockVec[1][gr*WORD_BITS +: WORD_BITS];
      assign refWords[gr]  = lockVec[2][gr*WORD_BITS +: WORD_BITS];
    end
  endgenerate

  always_comb begin
    lockNext = lockVec;
    for (int kd = 0; kd < KINDS; kd++) begin
      for (int r = 0; r < REGS; r++) begin
        if (wrKind[kd] && (cmd.regIdx == 8'(r))) begin
          lockNext[kd][r*WORD_BITS +: WORD_BITS] =
            lockVec[kd][r*WORD_BITS +: WORD_BITS] | wrData;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lockVec  <= '0;
      globLock <= '0;
      dbgReg   <= '0;
    end else begin
      lockVec <= lockNext;
      if (cmd.wrGlob) globLock <= globLock | (wrData[3:0] & GLOB_MASK);
      if (cmd.wrDbg && !globLock[2]) dbgReg <= wrData[DBG_BITS-1:0];
    end
  end

  always_comb begin
    rdNext = '0;
    case (cmd.rdSel)
      RD_GLOB: rdNext = {28'd0, globLock};
      RD_DBG:  rdNext = {{(32-DBG_BITS){1'b0}}, dbgReg};
      default: begin
        for (int r = 0; r < REGS; r++) begin
          if (cmd.regIdx == 8'(r)) begin
            case (cmd.rdSel)
              RD_PERM: rdNext = permWords[r];
              RD_PROG: rdNext = progWords[r];
              RD_SWR:  rdNext = swrWords[r];
              RD_REF:  rdNext = refWords[r];
              default: rdNext = '0;
            endcase
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdData <= '0;
    else if (cmd.rdStb) rdData <= rdNext;
  end

  assign progInhibit     = lockVec[0] | {NUM_WORDS{globLock[3]}};
  assign shadowWrInhibit = lockVec[1];
  assign refreshInhibit  = lockVec[2];
  assign upperLock       = globLock[0];
  assign dbgEnable       = dbgReg;

  // R3
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((lockVec & $past(lockVec)) == $past(lockVec)));

  // R3
  glob_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((globLock & $past(globLock)) == $past(globLock)));

  // R2
  zero_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrData == '0) |=> $stable(lockVec));

  // R8
  dbg_lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    globLock[2] |=> $stable(dbgReg));

  // R10
  undef_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.rdStb && cmd.rdSel == RD_NONE) |=> (rdData == '0));

  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd.rdStb |=> $stable(rdData));

endmodule

// File: rtl/fuse_lock_bank.sv
module fuse_lock_bank
  import fuse_lock_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int NUM_WORDS = 96,
  parameter int DBG_BITS  = 11
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wrEn,
  input  logic                 rdEn,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [31:0]          wrData,
  input  logic [NUM_WORDS-1:0] permLockIn,
  output logic [31:0]          rdData,
  output logic [NUM_WORDS-1:0] refreshInhibit,
  output logic [NUM_WORDS-1:0] shadowWrInhibit,
  output logic [NUM_WORDS-1:0] progInhibit,
  output logic                 upperLock,
  output logic [DBG_BITS-1:0]  dbgEnable
);

  localparam int REGS = NUM_WORDS / 32;

  lockCmd_t cmd;

  fuse_lock_ctrl #(.ADDR_W(ADDR_W), .REGS(REGS)) u_ctrl (
    .wrEn (wrEn),
    .rdEn (rdEn),
    .addr (addr),
    .cmd  (cmd)
  );

  fuse_lock_dp #(.NUM_WORDS(NUM_WORDS), .DBG_BITS(DBG_BITS)) u_dp (
    .clk             (clk),
    .rst_n           (rst_n),
    .cmd             (cmd),
    .wrData          (wrData),
    .permLockIn      (permLockIn),
    .rdData          (rdData),
    .refreshInhibit  (refreshInhibit),
    .shadowWrInhibit (shadowWrInhibit),
    .progInhibit     (progInhibit),
    .upperLock       (upperLock),
    .dbgEnable       (dbgEnable)
  );

endmodule

// File: tb/sim_fuse_lock_bank.sv
`timescale 1ns/1ps
module sim_fuse_lock_bank;

  localparam int NW = 96;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wrEn = 1'b0;
  logic          rdEn = 1'b0;
  logic [11:0]   addr = '0;
  logic [31:0]   wrData = '0;
  logic [NW-1:0] permLockIn = '0;
  logic [31:0]   rdData;
  logic [NW-1:0] refreshInhibit, shadowWrInhibit, progInhibit;
  logic          upperLock;
  logic [10:0]   dbgEnable;

  always #2.5 clk = ~clk;

  fuse_lock_bank u0 (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .permLockIn(permLockIn), .rdData(rdData),
    .refreshInhibit(refreshInhibit), .shadowWrInhibit(shadowWrInhibit),
    .progInhibit(progInhibit), .upperLock(upperLock), .dbgEnable(dbgEnable)
  );

  // Model of the lock state
  logic [NW-1:0] mProg, mSwr, mRef;
  logic [3:0]    mGlob;
  logic [10:0]   mDbg;
  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  task automatic modelReset();
    mProg = '0; mSwr = '0; mRef = '0; mGlob = '0; mDbg = '0;
  endtask

  task automatic modelWrite(input logic [11:0] a, input logic [31:0] d);
    if (a == 12'h010) mGlob = mGlob | (d[3:0] & 4'b1101);
    if (a == 12'h014 && !mGlob[2]) mDbg = d[10:0];
    for (int r = 0; r < 3; r++) begin
      if (a == 12'(12'h064 + 4*r)) mProg[32*r +: 32] = mProg[32*r +: 32] | d;
      if (a == 12'(12'h07C + 4*r)) mSwr[32*r +: 32]  = mSwr[32*r +: 32] | d;
      if (a == 12'(12'h094 + 4*r)) mRef[32*r +: 32]  = mRef[32*r +: 32] | d;
    end
  endtask

  function automatic logic [31:0] expRead(input logic [11:0] a);
    logic [31:0] v;
    v = '0;
    if (a == 12'h010) v = {28'd0, mGlob};
    if (a == 12'h014) v = {21'd0, mDbg};
    for (int r = 0; r < 3; r++) begin
      if (a == 12'(12'h04C + 4*r)) v = permLockIn[32*r +: 32];
      if (a == 12'(12'h064 + 4*r)) v = mProg[32*r +: 32];
      if (a == 12'(12'h07C + 4*r)) v = mSwr[32*r +: 32];
      if (a == 12'(12'h094 + 4*r)) v = mRef[32*r +: 32];
    end
    return v;
  endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
    modelWrite(a, d);
  endtask

  task automatic doRead(input string req, input logic [11:0] a);
    logic [31:0] e;
    @(negedge clk);
    addr = a; rdEn = 1'b1;
    e = expRead(a);
    @(negedge clk);
    rdEn = 1'b0;
    chk(req, 128'(rdData), 128'(e));
  endtask

  task automatic checkOuts(input string req);
    chk({req, " progInhibit"}, 128'(progInhibit), 128'(mProg | {NW{mGlob[3]}}));
    chk({req, " shadowWrInhibit"}, 128'(shadowWrInhibit), 128'(mSwr));
    chk({req, " refreshInhibit"}, 128'(refreshInhibit), 128'(mRef));
    chk({req, " dbgEnable"}, 128'(dbgEnable), 128'(mDbg));
    chk({req, " upperLock"}, 128'(upperLock), 128'(mGlob[0]));
  endtask

  function automatic logic [11:0] pickAddr(input int unsigned n);
    logic [11:0] tbl [14];
    tbl = '{12'h010, 12'h014, 12'h04C, 12'h050, 12'h054, 12'h064, 12'h068,
            12'h06C, 12'h07C, 12'h080, 12'h084, 12'h094, 12'h098, 12'h09C};
    if (n % 8 == 7) return 12'($urandom);
    return tbl[n % 14];
  endfunction

  task automatic applyReset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    modelReset();
  endtask

  initial begin : watchdog
    #(5.0 * 150000);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] d;
    logic [31:0] held;
    void'($urandom(32'h1234_5678));
    modelReset();
    permLockIn = {$urandom, $urandom, $urandom};
    repeat (2) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    checkOuts("R1");
    chk("R1 rdData", 128'(rdData), 128'd0);
    doRead("R1 prog bank", 12'h068);
    doRead("R1 glob", 12'h010);
    doRead("R1 dbg", 12'h014);

    // R7 debug mask
    doWrite(12'h014, 32'hFFFF_FFFF);
    doRead("R7 dbg masked", 12'h014);
    checkOuts("R7");
    doWrite(12'h014, 32'h0000_0155);
    doRead("R7 dbg rewrite", 12'h014);

    // R2 / R4 / R5 lock banks and word mapping
    doWrite(12'h068, 32'h0000_0020);
    chk("R5 word37", 128'(progInhibit[37]), 128'd1);
    doWrite(12'h068, 32'h0000_0000);
    chk("R2 zero write keeps word37", 128'(progInhibit[37]), 128'd1);
    doRead("R2 prog reg1", 12'h068);
    doWrite(12'h07C, 32'h8000_0001);
    chk("R4 swr word0", 128'(shadowWrInhibit[0]), 128'd1);
    chk("R4 swr word31", 128'(shadowWrInhibit[31]), 128'd1);
    doWrite(12'h09C, 32'h8000_0000);
    chk("R4 ref word95", 128'(refreshInhibit[95]), 128'd1);
    checkOuts("R4");

    // R9 permanent status read-only
    doRead("R9 perm0", 12'h04C);
    doWrite(12'h050, 32'hFFFF_FFFF);
    doRead("R9 perm1 after write", 12'h050);
    doRead("R9 perm2", 12'h054);
    checkOuts("R9");

    // R10 undefined offsets and read hold
    doRead("R10 0x018", 12'h018);
    doRead("R10 0x058", 12'h058);
    doRead("R10 misaligned 0x065", 12'h065);
    doRead("R10 0xFFC", 12'hFFC);
    doWrite(12'h070, 32'hFFFF_FFFF);
    doWrite(12'h066, 32'hFFFF_FFFF);
    checkOuts("R10 stray writes");
    doRead("R10 prog reg0", 12'h064);
    held = expRead(12'h064);
    repeat (3) @(negedge clk);
    chk("R10 rdData held", 128'(rdData), 128'(held));

    // R6 unimplemented global bit
    doWrite(12'h010, 32'h0000_00F2);
    doRead("R6 glob bit1 reads zero", 12'h010);

    // Random mix
    for (int i = 0; i < 400; i++) begin
      int unsigned n;
      n = $urandom;
      d = $urandom & $urandom & $urandom;
      if (n[0]) begin
        doWrite(pickAddr(n >> 1), d);
        checkOuts("R2 R3 random");
      end else begin
        doRead("R2 R3 random read", pickAddr(n >> 1));
      end
    end

    // R8 debug lock
    doWrite(12'h010, 32'h0000_0004);
    doWrite(12'h014, 32'h0000_02AA);
    doRead("R8 dbg locked", 12'h014);
    checkOuts("R8");

    // R5 global program lock, R6 upper lock
    doWrite(12'h010, 32'h0000_0008);
    chk("R5 all prog inhibited", 128'(progInhibit), 128'({NW{1'b1}}));
    doWrite(12'h010, 32'h0000_0001);
    chk("R6 upperLock", 128'(upperLock), 128'd1);
    doWrite(12'h010, 32'h0000_0000);
    doRead("R3 glob sticky", 12'h010);
    checkOuts("R3");

    // R1 reset after activity
    applyReset();
    checkOuts("R1 after reset");
    chk("R1 rdData after reset", 128'(rdData), 128'd0);
    doRead("R1 ref bank after reset", 12'h09C);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule